// File: doc/BRIEF.md
# Key-Sequence Armed Watchdog Timer

This block is a watchdog peripheral for a small microcontroller core. It listens on a plain register write bus (address, data, write strobe) and counts machine cycles, qualified by a per-cycle count enable, once it has been armed. Arming needs an exact two-byte key written to one write-only register. The same key, written again while the watchdog runs, restarts the count. Software has no way to disarm it.

A timeout-select input places between zero and seven prescaler bits in front of a 14-bit core counter. This stretches the timeout by a power of two. The select value is captured only when the key completes. When the counter reaches its limit, the block drives a reset request high for a fixed number of clock periods. The overflow also returns every internal state to its disarmed form, so the block is idle again when the pulse ends.

Top module: `keyseq_watchdog`

## Requirements
- R1: After reset `rst_req` is low and the watchdog is disarmed. Without the key sequence, no number of enabled cycles produces a pulse.
- R2: Writing 0x1E and then 0xE1 to address 0xA6, in two consecutive register writes, arms the watchdog. With select 0 and the enable held high, the overflow occurs on the 16383rd enabled cycle after the arming write.
- R3: Writing the same key pair while armed restarts the count. The next overflow comes 16383 << select enabled cycles after the second byte of that pair.
- R4: While armed, the count advances only on cycles where `cyc_en` is high. The timeout, counted in enabled cycles, does not depend on the enable pattern.
- R5: While armed, no register write disarms the watchdog. Stray values written to 0xA6 neither stop nor restart the countdown.
- R6: Key tracking works as follows. 0x1E written to 0xA6 marks the first byte as pending. The next write to 0xA6 completes the key only if it is 0xE1; any other value returns the tracker to idle. Writes to other addresses leave the pending state untouched.
- R7: On overflow, `rst_req` goes high at the next clock edge and stays high for exactly 96 clock cycles.
- R8: The timeout is 16383 × 2^sel enabled cycles, where sel is the value of `tmo_sel` captured when the key completes. A later change to `tmo_sel` has no effect until the next key completion.
- R9: Overflow disarms the watchdog and resets the key tracker. No further pulse occurs until the key is written again.
- R10: If `cyc_en` is high in the cycle where the key completes, the restart wins and that cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| cyc_en | input | 1 | Machine-cycle count enable |
| tmo_sel | input | 3 | Number of prescaler bits in the count path (0 to 7) |
| rst_req | output | 1 | Reset request pulse |

## Verification
The checker examines the following on every cycle:
- the exact pulse length;
- that arming can only follow a completed key;
- that the watchdog disarms only together with the start of a pulse;
- that the count holds when the enable is low;
- that a key completion always leaves the counter and prescaler at zero, even with the enable high.

Some behaviours need whole scenarios, and only the bench shows them:
- the exact timeout in enabled cycles for several select values and random enable patterns;
- that the select is captured only at a restart;
- that broken or interleaved key sequences are handled correctly;
- that no pulse follows an overflow unless the watchdog is armed again.

// File: rtl/keyseq_watchdog.sv
module keyseq_watchdog #(
  parameter logic [7:0] REG_ADDR  = 8'hA6,
  parameter logic [7:0] KEY_FIRST = 8'h1E,
  parameter logic [7:0] KEY_LAST  = 8'hE1,
  parameter int CNT_W     = 14,
  parameter int PRE_W     = 7,
  parameter int PULSE_LEN = 96,
  localparam int SEL_W  = $clog2(PRE_W + 1),
  localparam int PCNT_W = $clog2(PULSE_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             cyc_en,
  input  logic [SEL_W-1:0] tmo_sel,
  output logic             rst_req
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'((1 << CNT_W) - 2);

  logic              pend, armed;
  logic [CNT_W-1:0]  cnt;
  logic [PRE_W-1:0]  pre, pmask;
  logic [SEL_W-1:0]  sel_q;
  logic [PCNT_W-1:0] pcnt;
  logic              wr_hit, key_done, tick, ovf;

  assign wr_hit   = wr_en && (wr_addr == REG_ADDR);
  assign key_done = wr_hit && pend && (wr_data == KEY_LAST);

  always_comb
    for (int i = 0; i < PRE_W; i++)
      pmask[i] = (i < int'(sel_q));

  assign tick    = armed && cyc_en && ((pre & pmask) == pmask);
  assign ovf     = tick && (cnt == CNT_LAST) && !key_done;
  assign rst_req = |pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      armed <= 1'b0;
      cnt   <= '0;
      pre   <= '0;
      sel_q <= '0;
    end else begin
      if (ovf)
        pend <= 1'b0;
      else if (wr_hit)
        pend <= !pend && (wr_data == KEY_FIRST);

      if (key_done) begin
        armed <= 1'b1;
        cnt   <= '0;
        pre   <= '0;
        sel_q <= tmo_sel;
      end else if (ovf) begin
        armed <= 1'b0;
        cnt   <= '0;
        pre   <= '0;
      end else if (armed && cyc_en) begin
        pre <= pre + 1'b1;
        if (tick) cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pcnt <= '0;
    else if (ovf)        pcnt <= PCNT_W'(PULSE_LEN);
    else if (pcnt != '0) pcnt <= pcnt - 1'b1;
  end

endmodule

// File: rtl/keyseq_watchdog_chk.sv
module keyseq_watchdog_chk #(
  parameter logic [7:0] REG_ADDR  = 8'hA6,
  parameter logic [7:0] KEY_LAST  = 8'hE1,
  parameter int CNT_W     = 14,
  parameter int PRE_W     = 7,
  parameter int PULSE_LEN = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       wr_addr,
  input logic [7:0]       wr_data,
  input logic             cyc_en,
  input logic             rst_req,
  input logic             armed,
  input logic             key_done,
  input logic [CNT_W-1:0] cnt,
  input logic [PRE_W-1:0] pre
);

  logic [15:0] run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= '0;
    else        run <= rst_req ? run + 16'd1 : 16'd0;

  // R7
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (run == 16'(PULSE_LEN)));

  // R2
  arm_by_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(wr_en && wr_addr == REG_ADDR && wr_data == KEY_LAST));

  // R9
  disarm_on_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> $rose(rst_req));

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !cyc_en && !key_done) |=> $stable(cnt));

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_done |=> (cnt == '0 && pre == '0 && armed));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !rst_req) |=> !rst_req);

endmodule

bind keyseq_watchdog keyseq_watchdog_chk #(
  .REG_ADDR(REG_ADDR), .KEY_LAST(KEY_LAST), .CNT_W(CNT_W),
  .PRE_W(PRE_W), .PULSE_LEN(PULSE_LEN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .cyc_en(cyc_en), .rst_req(rst_req), .armed(armed),
  .key_done(key_done), .cnt(cnt), .pre(pre)
);

// File: tb/keyseq_watchdog_tb_top.sv
module keyseq_watchdog_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, cyc_en = 1'b0;
  logic [7:0] wr_addr = 8'h00, wr_data = 8'h00;
  logic [2:0] tmo_sel = 3'd0;
  logic rst_req;
  int vectors = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  keyseq_watchdog dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cyc_en(cyc_en), .tmo_sel(tmo_sel), .rst_req(rst_req)
  );

  function automatic int exp_timeout(int sel);
    return 16383 << sel;
  endfunction

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic arm(logic [2:0] sel);
    cyc_en = 1'b0;
    tmo_sel = sel;
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
  endtask

  task automatic run_to_pulse(int pct, int limit, output int en);
    en = 0;
    for (int k = 0; k < limit; k++) begin
      cyc_en = ($urandom % 100) < pct;
      @(posedge clk);
      if (cyc_en) en++;
      @(negedge clk);
      if (rst_req) break;
    end
    cyc_en = 1'b0;
  endtask

  task automatic run_en(int n, int pct);
    int en = 0;
    while (en < n) begin
      @(negedge clk);
      cyc_en = ($urandom % 100) < pct;
      @(posedge clk);
      if (cyc_en) en++;
    end
    @(negedge clk);
    cyc_en = 1'b0;
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (rst_req && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic idle_count(int n, output int highs);
    highs = 0;
    cyc_en = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (rst_req) highs++;
    end
    cyc_en = 1'b0;
  endtask

  always @(posedge clk) cycles++;

  initial begin
    wait (cycles >= 195000 || done);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int en, n, h;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 rst_req at reset", rst_req, 0);
    rst_n = 1'b1;

    // R1: no arming, no pulse
    idle_count(17000, h);
    check("R1 disarmed idle highs", h, 0);

    // R2 / R7: arm with sel 0, full enable
    arm(3'd0);
    run_to_pulse(100, 20000, en);
    check("R2 timeout sel0", en, exp_timeout(0));
    pulse_len(n);
    check("R7 pulse length", n, 96);

    // R9 + R6: after overflow disarmed; broken key 1E,1E,E1 must not arm
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    idle_count(17000, h);
    check("R9/R6 no pulse after overflow and broken key", h, 0);

    // R4: random enable pattern
    arm(3'd0);
    run_to_pulse(80, 25000, en);
    check("R4 enabled cycles to overflow", en, exp_timeout(0));
    pulse_len(n);
    check("R7 pulse length again", n, 96);

    // R3 / R10: service with cyc_en high during the key
    arm(3'd0);
    run_en(3000, 100);
    cyc_en = 1'b1;
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    run_to_pulse(100, 20000, en);
    check("R3/R10 timeout after service", en, exp_timeout(0));
    pulse_len(n);

    // R5: stray writes while armed do not disarm or restart
    arm(3'd0);
    run_en(5000, 100);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if (d == 8'h1E) d = 8'h00;
      wr(8'hA6, d);
    end
    wr(8'hA6, 8'hE1);
    run_to_pulse(100, 20000, en);
    check("R5 remaining after stray writes", en, exp_timeout(0) - 5000);
    pulse_len(n);

    // R6: write to another address between key bytes does not disturb
    cyc_en = 1'b0;
    wr(8'hA6, 8'h1E); wr(8'hA7, 8'h00); wr(8'hA5, 8'hE1); wr(8'hA6, 8'hE1);
    run_to_pulse(100, 20000, en);
    check("R6 arm across foreign writes", en, exp_timeout(0));
    pulse_len(n);

    // R6: 1E, 00, E1 does not arm
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h00); wr(8'hA6, 8'hE1);
    idle_count(200, h);
    check("R6 interrupted key ignored", h, 0);

    // R8: select captured at key; change afterwards ignored
    arm(3'd1);
    tmo_sel = 3'd0;
    run_to_pulse(100, 40000, en);
    check("R8 timeout sel1 latched", en, exp_timeout(1));
    pulse_len(n);
    check("R7 pulse length sel1", n, 96);
    check("R7 low after pulse", rst_req, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule